// File: doc/BRIEF.md
# Hot-Replace Rebuild and Verify Sequencer

This block steers one memory lane of a five-lane striped array (four data lanes plus one XOR parity lane) through a hot replacement and back into redundant service. A replace request names a lane. From the next cycle that lane is flagged as ignored, and the array runs in degraded, ECC-only mode. The sequencer then waits until the lane has been physically removed and reports present again.

Once the lane is back, the sequencer sweeps every address twice. The rebuild pass reads each stripe, forms the XOR of the four surviving lanes and writes the result into the returning lane. The verify pass reads each stripe again and checks that all five lanes XOR to zero and that no lane reports an ECC error. A clean verify restores redundancy. Any error leaves the lane offline in a held failure state until a new replace request arrives for that same lane.

Normal traffic always has priority on the memory port: the sweep only takes slots that traffic leaves free, and it resumes at the next pending address. Reads have a fixed latency of one cycle. The address range is set by a parameter.

Top module: `hr_seq`

## Requirements
- R1: After synchronous reset, `seq_state` is 0 (redundant), `lane_off` is zero, `redundant` is 1, and `rd_en`, `wr_en`, `err_pulse` and `rej_pulse` are all 0.
- R2: In state 0, a request whose lane index is 0 to 4 is accepted. In the next cycle `seq_state` is 1 (degraded), `lane_off` has only bit `repl_lane` set, and `redundant` is 0.
- R3: State 1 holds, with no sweep reads and `progress` at 0, until the chosen lane's `lane_up` bit has been seen low and is then seen high. The sequencer then enters state 2 (rebuild).
- R4: In states 2 and 3 (verify), sweep reads go out in ascending order from address 0 to the last address, at most one per cycle. `rd_en` is never high in the cycle after a cycle in which `host_busy` was high. A stalled sweep continues at the next pending address.
- R5: One cycle after each read response in state 2, `wr_en` is high. `wr_lane` is the chosen lane, `wr_addr` is the response address, and `wr_data` is the XOR of the other four lanes' words. Lane k occupies `rd_data[k*DW +: DW]`.
- R6: After the last rebuild response, state 3 reads every address again. A response with any `rd_ecc` bit set, or whose five lane words do not XOR to zero, raises `err_pulse` one cycle later, with `err_addr` set to that address.
- R7: During rebuild, an ECC flag on any lane other than the chosen one raises `err_pulse` for that address and forces the failure outcome.
- R8: If verify finishes with no error in either pass, the sequencer returns to state 0 with `lane_off` at zero and `redundant` at 1. Otherwise it enters state 4 (failed), keeps the lane flagged and `redundant` at 0, and stays there.
- R9: In state 4, a request for the same lane is accepted into state 1. A request for any other lane is rejected.
- R10: A request in states 1, 2 or 3, or with a lane index of 5 or more, is rejected. `rej_pulse` is high for the next cycle, and `lane_off` and the chosen lane are unchanged.
- R11: `progress` counts the sweep responses of the current pass. It restarts at 0 on entry to states 1, 2 and 3, and reads 2^AW at the end of the sequence.
- R12: `lane_off` is zero exactly when `seq_state` is 0. In every other state it has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repl_req | input | 1 | Replace request, one cycle |
| repl_lane | input | LW | Lane to replace |
| lane_up | input | NL | Per-lane presence |
| host_busy | input | 1 | Normal traffic takes the next memory slot |
| rd_en | output | 1 | Sweep read request |
| rd_addr | output | AW | Sweep read address |
| rd_valid | input | 1 | Read response, one cycle after `rd_en` |
| rd_data | input | NL*DW | All lane words of the response |
| rd_ecc | input | NL | Per-lane ECC error flags of the response |
| wr_en | output | 1 | Rebuild write |
| wr_addr | output | AW | Rebuild write address |
| wr_lane | output | LW | Lane being written |
| wr_data | output | DW | Reconstructed word |
| lane_off | output | NL | One-hot mask of the ignored lane |
| redundant | output | 1 | Full redundancy active |
| seq_state | output | 3 | 0 redundant, 1 degraded, 2 rebuild, 3 verify, 4 failed |
| progress | output | AW+1 | Responses completed in the current pass |
| err_pulse | output | 1 | Stripe error found |
| err_addr | output | AW | Address of the error |
| rej_pulse | output | 1 | Request rejected |

## Verification
A corrupted state register or lane index appears at `lane_off`, `redundant` or `seq_state` in the cycle after the faulty edge. The lane mask also shows it whenever its one-hot shape breaks. A broken sweep counter shows up on the next issued `rd_addr` or `wr_addr`, and in the final `progress` value. A lost or stuck error flag is only visible at the end of the verify pass, as the wrong outcome state, so every outcome path is run with an injected fault at a known address.

// File: rtl/hr_pkg.sv
package hr_pkg;
  typedef enum logic [2:0] {
    ST_REDUN = 3'd0,
    ST_DEGR  = 3'd1,
    ST_REBLD = 3'd2,
    ST_VERIF = 3'd3,
    ST_FAULT = 3'd4
  } hr_state_e;
endpackage

// File: rtl/hr_sweep.sv
// Address walker for one pass: issues reads into slots left free by traffic
// and counts the responses that come back.
module hr_sweep #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          active,
  input  logic          host_busy,
  input  logic          rsp_valid,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   rsp_cnt,
  output logic          last_rsp
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] CNT_END = (AW+1)'(DEPTH);

  logic [AW:0] iss_cnt;
  logic        issue;

  assign issue    = active && !host_busy && (iss_cnt < CNT_END);
  assign last_rsp = active && rsp_valid && (rsp_cnt == CNT_END - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      iss_cnt <= '0;
      rsp_cnt <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_en <= issue;
      if (issue) begin
        rd_addr <= iss_cnt[AW-1:0];
        iss_cnt <= iss_cnt + 1'b1;
      end
      if (active && rsp_valid) rsp_cnt <= rsp_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hr_stripe.sv
// Stripe arithmetic: rebuilds the chosen lane from the others and checks
// the full stripe during verify.
module hr_stripe #(
  parameter int NL = 5,
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int LW = $clog2(NL)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rsp_valid,
  input  logic [NL*DW-1:0] rsp_data,
  input  logic [NL-1:0]  rsp_ecc,
  input  logic [AW-1:0]  rsp_addr,
  input  logic [LW-1:0]  tgt,
  input  logic           rebuild,
  input  logic           verify,
  output logic           rsp_bad,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           err_pulse,
  output logic [AW-1:0]  err_addr
);
  logic [DW-1:0] word [NL];
  logic [DW-1:0] rec, par;
  logic [NL-1:0] tgt_mask;
  logic          src_ecc;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign word[g] = rsp_data[g*DW +: DW];
  end

  always_comb begin
    rec = '0;
    par = '0;
    for (int i = 0; i < NL; i++) begin
      par = par ^ word[i];
      if (i != int'(tgt)) rec = rec ^ word[i];
    end
  end

  assign tgt_mask = NL'(1) << tgt;
  assign src_ecc  = |(rsp_ecc & ~tgt_mask);
  assign rsp_bad  = (rebuild && src_ecc) || (verify && ((|rsp_ecc) || (|par)));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      err_pulse <= 1'b0;
      err_addr  <= '0;
    end else begin
      wr_en     <= rsp_valid && rebuild;
      err_pulse <= rsp_valid && rsp_bad;
      if (rsp_valid) begin
        wr_addr  <= rsp_addr;
        wr_data  <= rec;
        err_addr <= rsp_addr;
      end
    end
  end
endmodule

// File: rtl/hr_ctrl.sv
// Replacement state machine: request acceptance, lane swap detection,
// pass sequencing and outcome.
module hr_ctrl
  import hr_pkg::*;
#(
  parameter int NL = 5,
  parameter int LW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          repl_req,
  input  logic [LW-1:0] repl_lane,
  input  logic [NL-1:0] lane_up,
  input  logic          rsp_valid,
  input  logic          rsp_bad,
  input  logic          last_rsp,
  output hr_state_e     state,
  output logic [LW-1:0] tgt,
  output logic          pass_start,
  output logic          rej_pulse
);
  localparam logic [LW-1:0] LAST_LANE = LW'(NL - 1);

  hr_state_e nxt;
  logic      take, rej, seen_down, fail_q, fail_nx;

  assign fail_nx = fail_q || (rsp_valid && rsp_bad);

  always_comb begin
    nxt  = state;
    take = 1'b0;
    rej  = 1'b0;
    case (state)
      ST_REDUN: if (repl_req) begin
        if (repl_lane <= LAST_LANE) take = 1'b1;
        else                        rej  = 1'b1;
      end
      ST_FAULT: if (repl_req) begin
        if (repl_lane == tgt) take = 1'b1;
        else                  rej  = 1'b1;
      end
      ST_DEGR: begin
        rej = repl_req;
        if (seen_down && lane_up[tgt]) nxt = ST_REBLD;
      end
      ST_REBLD: begin
        rej = repl_req;
        if (last_rsp) nxt = ST_VERIF;
      end
      ST_VERIF: begin
        rej = repl_req;
        if (last_rsp) nxt = fail_nx ? ST_FAULT : ST_REDUN;
      end
      default: nxt = ST_REDUN;
    endcase
    if (take) nxt = ST_DEGR;
    pass_start = (nxt != state) &&
                 ((nxt == ST_DEGR) || (nxt == ST_REBLD) || (nxt == ST_VERIF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_REDUN;
      tgt       <= '0;
      seen_down <= 1'b0;
      fail_q    <= 1'b0;
      rej_pulse <= 1'b0;
    end else begin
      state     <= nxt;
      rej_pulse <= rej;
      if (take) begin
        tgt       <= repl_lane;
        seen_down <= 1'b0;
      end else if (state == ST_DEGR && !lane_up[tgt]) begin
        seen_down <= 1'b1;
      end
      if (state == ST_DEGR)
        fail_q <= 1'b0;
      else if (state == ST_REBLD || state == ST_VERIF)
        fail_q <= fail_nx;
    end
  end
endmodule

// File: rtl/hr_seq.sv
module hr_seq
  import hr_pkg::*;
#(
  parameter int NL = 5,
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int LW = $clog2(NL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             repl_req,
  input  logic [LW-1:0]    repl_lane,
  input  logic [NL-1:0]    lane_up,
  input  logic             host_busy,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_valid,
  input  logic [NL*DW-1:0] rd_data,
  input  logic [NL-1:0]    rd_ecc,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [LW-1:0]    wr_lane,
  output logic [DW-1:0]    wr_data,
  output logic [NL-1:0]    lane_off,
  output logic             redundant,
  output logic [2:0]       seq_state,
  output logic [AW:0]      progress,
  output logic             err_pulse,
  output logic [AW-1:0]    err_addr,
  output logic             rej_pulse
);
  hr_state_e     state;
  logic [LW-1:0] tgt;
  logic          pass_start, last_rsp, rsp_bad, sweeping;
  logic [AW:0]   rsp_cnt;

  assign sweeping = (state == ST_REBLD) || (state == ST_VERIF);

  hr_ctrl #(.NL(NL), .LW(LW)) u_ctrl (
    .clk(clk), .rst(rst), .repl_req(repl_req), .repl_lane(repl_lane),
    .lane_up(lane_up), .rsp_valid(rd_valid), .rsp_bad(rsp_bad),
    .last_rsp(last_rsp), .state(state), .tgt(tgt),
    .pass_start(pass_start), .rej_pulse(rej_pulse)
  );

  hr_sweep #(.AW(AW)) u_sweep (
    .clk(clk), .rst(rst), .clear(pass_start), .active(sweeping),
    .host_busy(host_busy), .rsp_valid(rd_valid), .rd_en(rd_en),
    .rd_addr(rd_addr), .rsp_cnt(rsp_cnt), .last_rsp(last_rsp)
  );

  hr_stripe #(.NL(NL), .DW(DW), .AW(AW), .LW(LW)) u_stripe (
    .clk(clk), .rst(rst), .rsp_valid(rd_valid), .rsp_data(rd_data),
    .rsp_ecc(rd_ecc), .rsp_addr(rsp_cnt[AW-1:0]), .tgt(tgt),
    .rebuild(state == ST_REBLD), .verify(state == ST_VERIF),
    .rsp_bad(rsp_bad), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_pulse(err_pulse), .err_addr(err_addr)
  );

  assign wr_lane   = tgt;
  assign seq_state = state;
  assign redundant = (state == ST_REDUN);
  assign lane_off  = (state == ST_REDUN) ? '0 : (NL'(1) << tgt);
  assign progress  = rsp_cnt;
endmodule

// File: rtl/hr_seq_chk.sv
module hr_seq_chk #(
  parameter int NL = 5,
  parameter int AW = 4,
  parameter int LW = $clog2(NL)
) (
  input logic          clk,
  input logic          rst,
  input logic          repl_req,
  input logic [LW-1:0] repl_lane,
  input logic          host_busy,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          wr_en,
  input logic [NL-1:0] lane_off,
  input logic          redundant,
  input logic [2:0]    seq_state,
  input logic          err_pulse,
  input logic          rej_pulse
);
  localparam logic [LW-1:0] LAST_LANE = LW'(NL - 1);

  p_mask_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd0) == (lane_off == '0));
  p_mask_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_off));
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd0 && repl_req && repl_lane <= LAST_LANE)
      |=> (seq_state == 3'd1 && !redundant));
  p_deg_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd1) |-> !rd_en);
  p_host_first_r4: assert property (@(posedge clk) disable iff (rst)
    host_busy |=> !rd_en);
  p_rd_step_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en) && $stable(seq_state))
      |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));
  p_wr_source_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rd_valid && seq_state == 3'd2));
  p_err_source_r6: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(rd_valid));
  p_fail_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd4 && !repl_req) |=> (seq_state == 3'd4));
  p_reject_r10: assert property (@(posedge clk) disable iff (rst)
    (repl_req && seq_state >= 3'd1 && seq_state <= 3'd3)
      |=> (rej_pulse && $stable(lane_off)));
endmodule

bind hr_seq hr_seq_chk #(.NL(NL), .AW(AW), .LW(LW)) u_hr_seq_chk (
  .clk(clk), .rst(rst), .repl_req(repl_req), .repl_lane(repl_lane),
  .host_busy(host_busy), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .wr_en(wr_en), .lane_off(lane_off),
  .redundant(redundant), .seq_state(seq_state), .err_pulse(err_pulse),
  .rej_pulse(rej_pulse)
);

// File: tb/test_hr_seq.sv
module test_hr_seq;
  localparam int NL = 5;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int LW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic repl_req = 1'b0;
  logic [LW-1:0] repl_lane = '0;
  logic [NL-1:0] lane_up = '1;
  logic host_busy = 1'b0;
  logic rd_en, wr_en, redundant, err_pulse, rej_pulse;
  logic [AW-1:0] rd_addr, wr_addr, err_addr;
  logic rd_valid = 1'b0;
  logic [NL*DW-1:0] rd_data = '0;
  logic [NL-1:0] rd_ecc = '0;
  logic [LW-1:0] wr_lane;
  logic [DW-1:0] wr_data;
  logic [NL-1:0] lane_off;
  logic [2:0] seq_state;
  logic [AW:0] progress;

  always #2 clk = ~clk;

  hr_seq #(.NL(NL), .DW(DW), .AW(AW), .LW(LW)) i_hr_seq (
    .clk(clk), .rst(rst), .repl_req(repl_req), .repl_lane(repl_lane),
    .lane_up(lane_up), .host_busy(host_busy), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ecc(rd_ecc), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lane(wr_lane),
    .wr_data(wr_data), .lane_off(lane_off), .redundant(redundant),
    .seq_state(seq_state), .progress(progress), .err_pulse(err_pulse),
    .err_addr(err_addr), .rej_pulse(rej_pulse)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: five lanes, lane 4 holds parity, one-cycle read latency.
  logic [DW-1:0] mem    [NL][DEPTH];
  logic [DW-1:0] golden [NL][DEPTH];
  int f_kind = 0;   // 0 none, 1 read bit flip, 2 ECC flag
  int f_lane = 0;
  int f_addr = 0;
  int cur_lane = 0;

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] p;
      p = '0;
      for (int l = 0; l < NL - 1; l++) begin
        golden[l][a] = DW'(l * 37 + a * 11 + 3);
        p = p ^ golden[l][a];
      end
      golden[NL-1][a] = p;
      for (int l = 0; l < NL; l++) mem[l][a] = golden[l][a];
    end
  end

  always @(posedge clk) begin
    rd_valid <= rd_en;
    if (rd_en) begin
      for (int l = 0; l < NL; l++) begin
        logic hit;
        hit = (l == f_lane) && (int'(rd_addr) == f_addr);
        rd_data[l*DW +: DW] <= mem[l][rd_addr] ^ ((f_kind == 1 && hit) ? 8'h10 : 8'h00);
        rd_ecc[l] <= (f_kind == 2) && hit;
      end
    end
    if (wr_en) mem[wr_lane][wr_addr] <= wr_data;
  end

  // Traffic pattern and monitors.
  int busy_mod = 0;
  int cyc = 0;
  logic hb_q = 1'b0;
  int rd_cnt = 0, wr_cnt = 0, err_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    host_busy <= (busy_mod != 0) && (cyc % busy_mod == 0);
  end
  always @(posedge clk) hb_q <= host_busy;

  always @(negedge clk) begin
    if (!rst) begin
      if (hb_q) chk(!rd_en, "R4 traffic priority", 32'(rd_en), 0);
      if (rd_en) begin
        chk(rd_addr == AW'(rd_cnt), "R4 sweep read order", 32'(rd_addr), 32'(AW'(rd_cnt)));
        rd_cnt++;
      end
      if (wr_en) begin
        chk(wr_addr == AW'(wr_cnt), "R5 write address", 32'(wr_addr), 32'(AW'(wr_cnt)));
        chk(int'(wr_lane) == cur_lane, "R5 write lane", 32'(wr_lane), 32'(cur_lane));
        chk(wr_data == golden[cur_lane][wr_addr], "R5 rebuilt data",
            32'(wr_data), 32'(golden[cur_lane][wr_addr]));
        wr_cnt++;
      end
      if (err_pulse) begin
        chk(int'(err_addr) == f_addr, "R6 R7 error address", 32'(err_addr), 32'(f_addr));
        err_cnt++;
      end
    end
  end

  // Stimulus helpers.
  task automatic pulse_req(input int lane);
    @(negedge clk);
    repl_req  = 1'b1;
    repl_lane = LW'(lane);
    @(negedge clk);
    repl_req = 1'b0;
  endtask

  task automatic remove_lane(input int lane);
    lane_up[lane] = 1'b0;
    for (int a = 0; a < DEPTH; a++) mem[lane][a] = DW'(8'hA5 ^ a);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      if (seq_state == 3'd0 || seq_state == 3'd4) break;
      @(negedge clk);
    end
  endtask

  task automatic run_seq(input int lane, input int busy, input int kind,
                         input int faddr, input int exp_st, input int exp_err);
    cur_lane = lane;
    busy_mod = busy;
    f_kind = kind;
    f_addr = faddr;
    f_lane = (kind == 2) ? (lane + 1) % NL : lane;
    rd_cnt = 0; wr_cnt = 0; err_cnt = 0;
    pulse_req(lane);
    chk(seq_state == 3'd1, "R2 R9 enter degraded", 32'(seq_state), 1);
    chk(lane_off == NL'(1) << lane, "R2 lane mask", 32'(lane_off), 32'(NL'(1) << lane));
    chk(!redundant, "R2 redundancy off", 32'(redundant), 0);
    remove_lane(lane);
    chk(seq_state == 3'd1, "R3 waits while lane absent", 32'(seq_state), 1);
    chk(progress == 0, "R11 progress cleared", 32'(progress), 0);
    lane_up[lane] = 1'b1;
    wait_end();
    chk(int'(seq_state) == exp_st, "R8 outcome state", 32'(seq_state), 32'(exp_st));
    chk(redundant == (exp_st == 0), "R8 redundancy flag", 32'(redundant), 32'(exp_st == 0));
    chk(lane_off == ((exp_st == 0) ? '0 : NL'(1) << lane), "R8 R12 final mask",
        32'(lane_off), 32'((exp_st == 0) ? '0 : NL'(1) << lane));
    chk(err_cnt == exp_err, "R6 R7 error count", 32'(err_cnt), 32'(exp_err));
    chk(rd_cnt == 2 * DEPTH, "R4 R6 reads in both passes", 32'(rd_cnt), 32'(2 * DEPTH));
    chk(wr_cnt == DEPTH, "R5 rebuild writes", 32'(wr_cnt), 32'(DEPTH));
    chk(progress == DEPTH, "R11 final progress", 32'(progress), 32'(DEPTH));
    for (int a = 0; a < DEPTH; a++)
      chk(mem[lane][a] == golden[lane][a], "R5 lane contents restored",
          32'(mem[lane][a]), 32'(golden[lane][a]));
    f_kind = 0;
    busy_mod = 0;
  endtask

  typedef struct packed {
    logic [2:0] lane;
    logic [1:0] busy;
    logic [1:0] fkind;
    logic [3:0] faddr;
    logic [2:0] exp_st;
    logic [1:0] exp_err;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd0, 2'd0, 2'd0, 4'd0, 3'd0, 2'd0},
    '{3'd4, 2'd3, 2'd0, 4'd0, 3'd0, 2'd0},
    '{3'd2, 2'd0, 2'd1, 4'd5, 3'd4, 2'd1},
    '{3'd2, 2'd2, 2'd0, 4'd0, 3'd0, 2'd0},
    '{3'd1, 2'd2, 2'd2, 4'd9, 3'd4, 2'd2},
    '{3'd1, 2'd3, 2'd0, 4'd0, 3'd0, 2'd0},
    '{3'd3, 2'd2, 2'd0, 4'd15, 3'd0, 2'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(seq_state == 3'd0, "R1 state", 32'(seq_state), 0);
    chk(lane_off == '0, "R1 mask", 32'(lane_off), 0);
    chk(redundant, "R1 redundant", 32'(redundant), 1);
    chk(!rd_en && !wr_en && !err_pulse && !rej_pulse, "R1 strobes idle",
        32'({rd_en, wr_en, err_pulse, rej_pulse}), 0);

    foreach (VECS[i])
      run_seq(int'(VECS[i].lane), int'(VECS[i].busy), int'(VECS[i].fkind),
              int'(VECS[i].faddr), int'(VECS[i].exp_st), int'(VECS[i].exp_err));

    // R10 out-of-range lane index
    pulse_req(5);
    chk(rej_pulse, "R10 lane index out of range", 32'(rej_pulse), 1);
    chk(seq_state == 3'd0, "R10 state unchanged", 32'(seq_state), 0);

    // R3 and R10: degraded hold and rejection during degraded and rebuild
    cur_lane = 3; rd_cnt = 0; wr_cnt = 0; err_cnt = 0;
    pulse_req(3);
    repeat (10) @(negedge clk);
    chk(seq_state == 3'd1, "R3 holds until lane drops", 32'(seq_state), 1);
    chk(rd_cnt == 0, "R3 no sweep in degraded", 32'(rd_cnt), 0);
    pulse_req(0);
    chk(rej_pulse, "R10 reject in degraded", 32'(rej_pulse), 1);
    chk(lane_off == 5'b01000, "R10 mask kept", 32'(lane_off), 32'h08);
    remove_lane(3);
    lane_up[3] = 1'b1;
    for (int i = 0; i < 20 && seq_state != 3'd2; i++) @(negedge clk);
    chk(seq_state == 3'd2, "R3 rebuild entered", 32'(seq_state), 2);
    pulse_req(1);
    chk(rej_pulse, "R10 reject during sweep", 32'(rej_pulse), 1);
    chk(lane_off == 5'b01000, "R10 lane unchanged", 32'(lane_off), 32'h08);
    wait_end();
    chk(seq_state == 3'd0, "R8 clean return", 32'(seq_state), 0);

    // R9: failed state accepts only the same lane
    run_seq(0, 0, 1, 7, 4, 1);
    pulse_req(1);
    chk(rej_pulse, "R9 other lane rejected", 32'(rej_pulse), 1);
    chk(seq_state == 3'd4, "R9 failed state held", 32'(seq_state), 4);
    chk(lane_off == 5'b00001, "R9 failed mask held", 32'(lane_off), 1);
    run_seq(0, 3, 0, 0, 0, 0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule